// File: doc/BRIEF.md
# Byte-Tagged Serial Flash Word Path

This block is the word-level data path of a serial flash controller. Software pushes transmit words through one of four write-only data addresses. The address chosen tells the block how many bytes of the 32-bit word are meaningful: one, two, three or all four. Each queued word keeps that byte count beside it in the transmit queue. A single-wire serializer shifts out only the meaningful bytes, with sclk idle low and one bit per two system clocks.

Each byte shifted out also shifts one byte in from the slave's data line. This includes padding and dummy bytes. The bytes received for one queued word are packed into a 32-bit word that enters a receive queue. Software drains that queue by reading a read-only data address. For a word shorter than four bytes, the received bytes sit in the top byte lanes and the unused lower lanes read as zero.

Both queues are 63 words deep. Software must let the transmit queue run empty before it changes from one byte-count address to another, and the block relies on that.

Top module: `sfc_word_path`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty, busy is low, sclk and mosi are low, the overflow flag is clear, and a read of the receive address returns 0.
- R2: A write to address 0x1C queues a four-byte word. The serializer produces exactly 32 rising sclk edges for it.
- R3: Writes to addresses 0x80, 0x84 and 0x88 queue words of one, two and three bytes. Only 8, 16 or 24 rising sclk edges are produced for them.
- R4: Bytes are sent starting at byte lane 0 (bits 7:0) and going upward. Within each byte the most significant bit goes first. mosi is held steady while sclk is high, and the slave line is sampled at the end of each high phase.
- R5: A received word of N bytes places the first received byte in lane 4-N and the last in lane 3 (bits 31:24). Each byte's first-sampled bit is its most significant bit, and the lower 4-N lanes are zero.
- R6: A read at address 0x20 returns the oldest receive word and removes it in the same cycle. When the receive queue is empty, the read returns 0 and nothing changes.
- R7: Each queue holds 63 words. A transmit write while the transmit queue is full is dropped and sets a sticky overflow flag that only reset clears.
- R8: A new word starts only while enable is high and the transmit queue is non-empty. busy is high exactly while a word is being shifted. With enable low, no sclk edge occurs.
- R9: Each transmitted word, padding included, yields exactly one receive word, in the order the words were queued.
- R10: Writes to any other address queue nothing. Reads of any other address return 0 and do not remove a receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows the serializer to start new words |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_overflow | output | 1 | Sticky flag: a transmit write was dropped |
| busy | output | 1 | Serializer shifting a word |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
A table of words of every byte count goes through a mosi-to-miso loopback. The data patterns have distinct, asymmetric bytes, so the captured mosi stream reveals a reversed lane or bit order, and the sclk edge count reveals a wrong byte tag. A reversed packing order or a wrong lane offset shows in the received word. An inverted loopback separates sampling of the slave line from any echo of the transmit word. Filling the transmit queue with enable low tests the depth limit, the dropped write and the start gate. The long drain that follows tests ordering across the full receive queue and the empty-read value.

// File: rtl/sfc_word_pkg.sv
// Shared constants, entry type and address decode for the word path.
// Assumes an 8-bit register byte address and a 32-bit data word.
package sfc_word_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LEN_W   = $clog2(LANES);
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] A_TX_FULLWORD = 8'h1C;
    localparam logic [ADDR_W-1:0] A_TX_ONE      = 8'h80;
    localparam logic [ADDR_W-1:0] A_TX_TWO      = 8'h84;
    localparam logic [ADDR_W-1:0] A_TX_THREE    = 8'h88;
    localparam logic [ADDR_W-1:0] A_RX_DATA     = 8'h20;

    // One transmit queue entry: byte count minus one, then the word.
    typedef struct packed {
        logic [LEN_W-1:0]  len_m1;
        logic [WORD_W-1:0] word;
    } tx_entry_t;

    // True for any of the four transmit data addresses.
    function automatic logic is_tx_addr(input logic [ADDR_W-1:0] a);
        return (a == A_TX_FULLWORD) || (a == A_TX_ONE) ||
               (a == A_TX_TWO) || (a == A_TX_THREE);
    endfunction

    // Byte count minus one selected by a transmit address.
    function automatic logic [LEN_W-1:0] len_of_addr(input logic [ADDR_W-1:0] a);
        logic [LEN_W-1:0] r;
        case (a)
            A_TX_ONE:   r = LEN_W'(0);
            A_TX_TWO:   r = LEN_W'(1);
            A_TX_THREE: r = LEN_W'(2);
            default:    r = LEN_W'(LANES - 1);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sfc_fifo.sv
// Synchronous first-in first-out queue of any depth (not only powers of two).
// Push when full and pop when empty are ignored. rdata shows the head entry.
module sfc_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign rdata   = mem[rd_ptr];

    // Storage write; no reset needed on the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sfc_tx_decode.sv
// Turns register writes into tagged transmit entries. A transmit write seen
// while the queue is full is dropped here and latches a sticky overflow flag.
module sfc_tx_decode
    import sfc_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              q_full,
    output logic              q_push,
    output tx_entry_t         q_entry,
    output logic              overflow
);
    logic hit;

    assign hit            = bus_wr && is_tx_addr(bus_addr);
    assign q_push         = hit && !q_full;
    assign q_entry.len_m1 = len_of_addr(bus_addr);
    assign q_entry.word   = bus_wdata;

    // Sticky record of a dropped transmit write.
    always_ff @(posedge clk) begin
        if (!rst_n)               overflow <= 1'b0;
        else if (hit && q_full)   overflow <= 1'b1;
    end
endmodule

// File: rtl/sfc_serdes.sv
// Single-wire shifter. It takes one tagged entry, sends its valid bytes from
// lane 0 upward with the MSB first, and samples miso at the end of each sclk
// high phase. Received bytes are shifted in from the top, so an N-byte word
// lands in the upper N lanes. Each bit takes two clocks: sclk low, then high.
module sfc_serdes
    import sfc_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_valid,
    input  tx_entry_t         tx_entry,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam logic [2:0] BIT_LAST = 3'd7;

    logic              active_q, phase_q;
    logic [2:0]        bit_q;
    logic [LEN_W-1:0]  lane_q, last_q;
    logic [WORD_W-1:0] sh_q, rxw_q;
    logic [7:0]        rxb_q, rxb_next, lane0;
    logic              start, bit_end, byte_end, word_end;

    assign start    = !active_q && enable && tx_valid;
    assign bit_end  = active_q && phase_q;
    assign byte_end = bit_end && (bit_q == BIT_LAST);
    assign word_end = byte_end && (lane_q == last_q);
    assign rxb_next = {rxb_q[6:0], miso};
    assign lane0    = sh_q[7:0];

    assign tx_pop  = start;
    assign rx_push = word_end;
    assign rx_word = {rxb_next, rxw_q[WORD_W-1:8]};
    assign busy    = active_q;
    assign sclk    = active_q && phase_q;
    assign mosi    = active_q && lane0[BIT_LAST - bit_q];

    // Sequencing of words, bytes, bits and sclk phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            bit_q    <= '0;
            lane_q   <= '0;
            last_q   <= '0;
            sh_q     <= '0;
            rxw_q    <= '0;
            rxb_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            bit_q    <= '0;
            lane_q   <= '0;
            last_q   <= tx_entry.len_m1;
            sh_q     <= tx_entry.word;
            rxw_q    <= '0;
        end else if (active_q) begin
            phase_q <= !phase_q;
            if (bit_end) begin
                rxb_q <= rxb_next;
                if (bit_q == BIT_LAST) begin
                    bit_q <= '0;
                    sh_q  <= sh_q >> 8;
                    rxw_q <= rx_word;
                    if (lane_q == last_q) active_q <= 1'b0;
                    else                  lane_q   <= lane_q + 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sfc_word_path.sv
// Top of the tagged word path: register decode, two 63-word queues and the
// shifter. It assumes software drains the transmit queue before it changes
// the byte-count address. Reads are combinational; the pop happens at the edge.
module sfc_word_path
    import sfc_word_pkg::*;
#(
    parameter int DEPTH = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              tx_overflow,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int ENTRY_W = $bits(tx_entry_t);

    tx_entry_t         in_entry, head_entry;
    logic [ENTRY_W-1:0] head_raw;
    logic              tx_push, tx_pop, rx_push, rd_hit;
    logic [WORD_W-1:0] rx_word, rx_head;

    sfc_tx_decode u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .q_full(tx_full), .q_push(tx_push),
        .q_entry(in_entry), .overflow(tx_overflow)
    );

    sfc_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(in_entry),
        .pop(tx_pop), .rdata(head_raw), .empty(tx_empty), .full(tx_full)
    );
    assign head_entry = head_raw;

    sfc_serdes u_sd (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_valid(!tx_empty),
        .tx_entry(head_entry), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_word(rx_word), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    sfc_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rd_hit), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
    );

    // Receive register read: head word, or zero when empty or other address.
    assign rd_hit    = bus_rd && (bus_addr == A_RX_DATA);
    assign bus_rdata = (rd_hit && !rx_empty) ? rx_head : '0;
endmodule

// File: rtl/sfc_word_path_checks.sv
// Property checker for sfc_word_path, bound to every instance of it.
module sfc_word_path_checks
    import sfc_word_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              tx_overflow,
    input logic              busy,
    input logic              sclk,
    input logic              mosi
);
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow |=> tx_overflow);

    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_tx_addr(bus_addr) && tx_full) |=> tx_overflow);

    p_full_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(enable) && !$past(tx_empty)));

    p_idle_sclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !mosi));

    p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rx_empty) |-> (bus_rdata == '0));
endmodule

bind sfc_word_path sfc_word_path_checks u_checks (.*);

// File: tb/sfc_word_path_test.sv
`timescale 1ns/1ps
module sfc_word_path_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_empty, tx_full, rx_empty, rx_full, tx_overflow, busy, sclk, mosi;
    logic        invert = 1'b0;
    logic        miso;

    int checks = 0, errors = 0;
    int edges = 0;
    logic [31:0] stream = '0;

    always #2 clk = ~clk;
    assign miso = invert ? ~mosi : mosi;

    sfc_word_path uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_overflow(tx_overflow), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Serial monitor: counts rising sclk edges and captures mosi in order.
    always @(posedge sclk) begin
        edges  = edges + 1;
        stream = {stream[30:0], mosi};
    end

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rx;
        logic [31:0] exp_stream;
        logic [7:0]  exp_edges;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h1C, 32'hA1B2C3D4, 32'hA1B2C3D4, 32'hD4C3B2A1, 8'd32},
        '{8'h80, 32'h123456F0, 32'hF0000000, 32'h000000F0, 8'd8},
        '{8'h84, 32'hDEAD5A3C, 32'h5A3C0000, 32'h00003C5A, 8'd16},
        '{8'h88, 32'h00817E01, 32'h817E0100, 32'h00017E81, 8'd24},
        '{8'h1C, 32'h00000000, 32'h00000000, 32'h00000000, 8'd32},
        '{8'h1C, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd32}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(tx_empty && !busy)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_empty && rx_empty && !busy && !sclk && !mosi && !tx_overflow && !tx_full,
              "R1 reset flags", {26'd0, tx_empty, rx_empty, busy, sclk, mosi, tx_overflow},
              32'h30);
        bus_read(8'h20, rd);
        check(rd == 0, "R1 reset read", rd, 0);

        // R2 R3 R4 R5 R9: vector table through loopback
        enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            edges = 0; stream = '0;
            bus_write(VECS[i].addr, VECS[i].data);
            @(negedge clk);
            check(busy, "R8 busy while shifting", 32'(busy), 1);
            wait_idle();
            check(edges == int'(VECS[i].exp_edges), "R2 R3 sclk edge count",
                  edges, 32'(VECS[i].exp_edges));
            check(stream == VECS[i].exp_stream, "R4 mosi order", stream, VECS[i].exp_stream);
            check(!rx_empty, "R9 one receive word", 32'(rx_empty), 0);
            bus_read(8'h20, rd);
            check(rd == VECS[i].exp_rx, "R5 receive packing", rd, VECS[i].exp_rx);
            check(rx_empty, "R6 read pops", 32'(rx_empty), 1);
        end

        // R5 inverted loopback: sampling of miso, not an echo of the word
        invert = 1'b1;
        bus_write(8'h84, 32'h000000FF);
        wait_idle();
        bus_read(8'h20, rd);
        check(rd == 32'hFF000000, "R5 inverted sample", rd, 32'hFF000000);
        invert = 1'b0;

        // R10 other addresses
        bus_write(8'h24, 32'h55AA55AA);
        @(negedge clk);
        check(tx_empty && !busy, "R10 write ignored", 32'(tx_empty), 1);
        bus_write(8'h1C, 32'h0BADF00D);
        wait_idle();
        bus_read(8'h24, rd);
        check(rd == 0, "R10 other read zero", rd, 0);
        check(!rx_empty, "R10 other read no pop", 32'(rx_empty), 0);
        bus_read(8'h20, rd);
        check(rd == 32'h0BADF00D, "R9 word kept", rd, 32'h0BADF00D);

        // R7 R8 fill with enable low
        enable = 1'b0;
        edges = 0;
        for (int i = 0; i < 63; i++) bus_write(8'h1C, 32'(i) + 32'h100);
        check(tx_full && !tx_overflow, "R7 full at 63", {30'd0, tx_full, tx_overflow}, 32'h2);
        check(edges == 0 && !busy, "R8 no start when disabled", edges, 0);
        bus_write(8'h1C, 32'hDEADDEAD);
        check(tx_overflow, "R7 overflow set", 32'(tx_overflow), 1);
        enable = 1'b1;
        wait_idle();
        check(tx_overflow, "R7 overflow sticky", 32'(tx_overflow), 1);
        check(rx_full, "R7 receive holds 63", 32'(rx_full), 1);
        for (int i = 0; i < 63; i++) begin
            bus_read(8'h20, rd);
            check(rd == 32'(i) + 32'h100, "R9 order", rd, 32'(i) + 32'h100);
        end
        check(rx_empty, "R7 dropped word absent", 32'(rx_empty), 1);
        bus_read(8'h20, rd);
        check(rd == 0, "R6 empty read zero", rd, 0);

        // R1 reset clears the sticky flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!tx_overflow && tx_empty, "R1 reset clears overflow", 32'(tx_overflow), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule